// File: doc/BRIEF.md
# DiSEqC Slave Command Processor

This block is the command layer of a satellite-bus slave for a low-noise block or a signal switcher. A bit-level receiver ahead of it turns the bus tone into bytes and marks where each frame starts and ends. The block keeps the frame and decides whether it is meant for this slave, from the framing byte and the address byte. It then runs the command.

The switching commands change two four-bit port groups. The committed group holds oscillator band, polarization, position and option. The uncommitted group holds four independent switches S1 to S4. Each accepted switching command raises a one-cycle update request. A contention flag gates the address reply and address move commands. A small parameter store holds the slave address, the local-oscillator table numbers, the output configuration and a serial byte. Commands can read and write this store, and a one-way lock can freeze it.

Reply frames go to a two-byte queue, and a transmitter drains it one byte at a time. A legacy-mode output is high after reset and drops at the first accepted frame, so the tone/voltage fallback path can be switched off. The reset command raises it again.

Top module: `dsq_slave_core`

## Requirements
- R1: A frame is acted on only when its second byte equals the programmed slave address (reset value 14h), 10h or 00h; frames with any other address change nothing.
- R2: Only framing bytes E0h to E3h are accepted. A reply is queued only when bit 1 of the framing byte is set (E2h, E3h).
- R3: Commands 20h–27h write committed bit cmd[1:0] with value cmd[2]. Bit 0 is band (0 low, 1 high), bit 1 polarization, bit 2 position and bit 3 option. Commands 28h–2Fh write uncommitted bit cmd[1:0] (switch S1..S4) with value cmd[2] (0 input A, 1 input B).
- R4: Command 38h loads the low four bits of its data byte into the committed group, and 39h does the same for the uncommitted group. 14h and 15h reply E4h then {0000, group}.
- R5: 04h sets and 06h clears the contention flag. 05h replies E4h, address only while the flag is set, and 07h only while it is clear.
- R6: 08h moves the slave address to its data byte only while the contention flag is set, and 09h only while it is clear.
- R7: 0Fh idx val writes parameter idx. 0Dh idx replies E4h followed by the parameter, or FFh for an index beyond the store. The reset values are: index 0 address 14h, index 1 oscillator numbers 00h, index 2 output configuration 0Ah, index 3 serial 1Bh.
- R8: The exact frame E0h addr 0Fh FFh FFh sets a lock. After that, no 0Fh command changes any parameter. The same bytes under another framing byte do not lock.
- R9: The legacy_mode output is 1 after reset and drops at the first accepted frame. Command 00h sets it back to 1 and clears the contention flag.
- R10: 02h raises standby and 03h lowers it.
- R11: Parameter 1 holds the high-band entry number in bits 7:4 and the low-band entry number in bits 3:0. 52h replies the low number and 53h the high number. 51h replies the number chosen by committed bit 0. Each reply is E4h, {0000, number}.
- R12: A frame whose length does not match its command (3 bytes plain; 4 for 08h, 09h, 0Dh, 38h, 39h; 5 for 0Fh), a frame longer than five bytes, and an unknown command all have no effect.
- R13: The reply queue presents E4h first and the data byte after one pop, and is empty after the second pop. A new reply overwrites a pending one completely.
- R14: port_upd is high for exactly one cycle after each accepted switching or group-write command, even when the value does not change, and the group outputs change at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start-of-frame strobe, clears the frame buffer |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe, starts command execution |
| rep_pop | input | 1 | Transmitter takes the current reply byte |
| rep_valid | output | 1 | A reply byte is pending |
| rep_byte | output | 8 | Current reply byte |
| port_grp0 | output | GRP_W | Committed switch group |
| port_grp1 | output | GRP_W | Uncommitted switch group |
| port_upd | output | 1 | One-cycle port-update request |
| standby | output | 1 | Peripheral standby control |
| legacy_mode | output | 1 | Legacy tone/voltage signalling enabled |

## Verification
The hardest state to reach is a moved slave address under a set contention flag, followed by the lock. Both can only be seen through later frames that address the slave by its new value. The bench builds this up in steps: it sets the flag, shows that the gated move is refused, moves the address, and checks that the old address no longer answers. It then moves the address back, writes a parameter, locks the store, and shows through a read command that a later write left the stored value unchanged. Reply overwrite is reached by sending a second reply-requesting command while a reply is still pending, once with the queue full and once after a single pop.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam logic [7:0] REPLY_HDR = 8'hE4;
  localparam logic [7:0] BCAST_A   = 8'h10;
  localparam logic [7:0] BCAST_B   = 8'h00;
  localparam logic [7:0] LOCK_FRM  = 8'hE0;

  localparam logic [7:0] C_RESET = 8'h00;
  localparam logic [7:0] C_STBY  = 8'h02;
  localparam logic [7:0] C_PWRON = 8'h03;
  localparam logic [7:0] C_CSET  = 8'h04;
  localparam logic [7:0] C_CADR  = 8'h05;
  localparam logic [7:0] C_CCLR  = 8'h06;
  localparam logic [7:0] C_ADR   = 8'h07;
  localparam logic [7:0] C_MOVC  = 8'h08;
  localparam logic [7:0] C_MOV   = 8'h09;
  localparam logic [7:0] C_PRD   = 8'h0D;
  localparam logic [7:0] C_PWR   = 8'h0F;
  localparam logic [7:0] C_RDG0  = 8'h14;
  localparam logic [7:0] C_RDG1  = 8'h15;
  localparam logic [7:0] C_WRG0  = 8'h38;
  localparam logic [7:0] C_WRG1  = 8'h39;
  localparam logic [7:0] C_LOCUR = 8'h51;
  localparam logic [7:0] C_LOLO  = 8'h52;
  localparam logic [7:0] C_LOHI  = 8'h53;

  // expected frame length for a command; 0 marks an unknown command
  function automatic logic [2:0] cmd_len(input logic [7:0] c);
    logic [2:0] n;
    n = 3'd0;
    if (c[7:4] == 4'h2) n = 3'd3;
    case (c)
      C_RESET, C_STBY, C_PWRON, C_CSET, C_CADR, C_CCLR, C_ADR,
      C_RDG0, C_RDG1, C_LOCUR, C_LOLO, C_LOHI: n = 3'd3;
      C_MOVC, C_MOV, C_PRD, C_WRG0, C_WRG1:    n = 3'd4;
      C_PWR:                                   n = 3'd5;
      default: ;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/dsq_frame_rx.sv
module dsq_frame_rx #(
  parameter int MAX_LEN = 5,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_sof,
  input  logic                      rx_valid,
  input  logic [7:0]                rx_byte,
  input  logic                      rx_eof,
  output logic [MAX_LEN-1:0][7:0]   frm_bytes,
  output logic [LEN_W-1:0]          frm_len,
  output logic                      frm_ovf,
  output logic                      frm_done
);
  logic [MAX_LEN-1:0][7:0] buf_q, buf_d;
  logic [LEN_W-1:0]        cnt_q, cnt_d;
  logic                    ovf_q, ovf_d;
  logic                    done_q, done_d;

  always_comb begin
    buf_d  = buf_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    done_d = 1'b0;
    if (rx_sof) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (rx_valid) begin
      if (cnt_q == LEN_W'(MAX_LEN)) begin
        ovf_d = 1'b1;
      end else begin
        for (int i = 0; i < MAX_LEN; i++)
          if (cnt_q == LEN_W'(i)) buf_d[i] = rx_byte;
        cnt_d = cnt_q + 1'b1;
      end
    end else if (rx_eof) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      done_q <= done_d;
    end
  end

  assign frm_bytes = buf_q;
  assign frm_len   = cnt_q;
  assign frm_ovf   = ovf_q;
  assign frm_done  = done_q;
endmodule

// File: rtl/dsq_param_mem.sv
module dsq_param_mem #(
  parameter int N_PARAM = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_force,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic       lock_req,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] slave_addr,
  output logic [7:0] lo_tbl,
  output logic       locked
);
  function automatic logic [7:0] def_val(input int i);
    case (i)
      0:       return 8'h14;
      1:       return 8'h00;
      2:       return 8'h0A;
      3:       return 8'h1B;
      default: return 8'hFF;
    endcase
  endfunction

  logic [7:0] mem_q [N_PARAM];
  logic [7:0] mem_d [N_PARAM];
  logic       lock_q, lock_d;
  logic       wr_ok;

  assign wr_ok  = wr_en && (!lock_q || wr_force);
  assign lock_d = lock_q || lock_req;

  always_comb begin
    for (int i = 0; i < N_PARAM; i++) begin
      mem_d[i] = mem_q[i];
      if (wr_ok && wr_idx == 8'(i)) mem_d[i] = wr_data;
    end
  end

  generate
    for (genvar g = 0; g < N_PARAM; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[g] <= def_val(g);
        else        mem_q[g] <= mem_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < N_PARAM; i++)
      if (rd_idx == 8'(i)) rd_data = mem_q[i];
  end

  assign slave_addr = mem_q[0];
  assign lo_tbl     = mem_q[1];
  assign locked     = lock_q;
endmodule

// File: rtl/dsq_reply_q.sv
module dsq_reply_q (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] ld_b0,
  input  logic [7:0] ld_b1,
  input  logic       pop,
  output logic       valid,
  output logic [7:0] head
);
  logic [7:0] b0_q, b0_d, b1_q, b1_d;
  logic [1:0] cnt_q, cnt_d;

  always_comb begin
    b0_d  = b0_q;
    b1_d  = b1_q;
    cnt_d = cnt_q;
    if (load) begin
      b0_d  = ld_b0;
      b1_d  = ld_b1;
      cnt_d = 2'd2;
    end else if (pop && cnt_q != 2'd0) begin
      b0_d  = b1_q;
      cnt_d = cnt_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0_q  <= '0;
      b1_q  <= '0;
      cnt_q <= '0;
    end else begin
      b0_q  <= b0_d;
      b1_q  <= b1_d;
      cnt_q <= cnt_d;
    end
  end

  assign valid = (cnt_q != 2'd0);
  assign head  = b0_q;
endmodule

// File: rtl/dsq_cmd_exec.sv
module dsq_cmd_exec
  import dsq_pkg::*;
#(
  parameter int MAX_LEN = 5,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int GRP_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MAX_LEN-1:0][7:0] frm_bytes,
  input  logic [LEN_W-1:0]        frm_len,
  input  logic                    frm_ovf,
  input  logic                    frm_done,
  input  logic [7:0]              slave_addr,
  input  logic [7:0]              lo_tbl,
  input  logic [7:0]              rd_data,
  output logic [7:0]              rd_idx,
  output logic                    mem_wr,
  output logic                    mem_force,
  output logic [7:0]              mem_idx,
  output logic [7:0]              mem_data,
  output logic                    mem_lock,
  output logic                    rep_load,
  output logic [7:0]              rep_b0,
  output logic [7:0]              rep_b1,
  output logic [GRP_W-1:0]        grp0,
  output logic [GRP_W-1:0]        grp1,
  output logic                    upd,
  output logic                    stby,
  output logic                    legacy
);
  localparam int PAD_W = 8 - GRP_W;

  logic [7:0] fb, ad, cm, p0, p1;
  logic       addr_ok, frm_ok, len_ok, go, rq;
  logic [2:0] need;
  logic [3:0] lo_sel;

  logic [GRP_W-1:0] g0_q, g0_d, g1_q, g1_d;
  logic             upd_q, upd_d, stby_q, stby_d, leg_q, leg_d, cont_q, cont_d;

  assign fb = frm_bytes[0];
  assign ad = frm_bytes[1];
  assign cm = frm_bytes[2];
  assign p0 = frm_bytes[3];
  assign p1 = frm_bytes[4];

  assign addr_ok = (ad == slave_addr) || (ad == BCAST_A) || (ad == BCAST_B);
  assign frm_ok  = (fb[7:2] == 6'b111000);
  assign need    = cmd_len(cm);
  assign len_ok  = (need != 3'd0) && !frm_ovf && (frm_len == LEN_W'(need));
  assign go      = frm_done && frm_ok && addr_ok && len_ok;
  assign rq      = fb[1];
  assign rd_idx  = p0;
  assign lo_sel  = (cm == C_LOHI || (cm == C_LOCUR && g0_q[0])) ? lo_tbl[7:4] : lo_tbl[3:0];

  always_comb begin
    g0_d      = g0_q;
    g1_d      = g1_q;
    upd_d     = 1'b0;
    stby_d    = stby_q;
    leg_d     = leg_q;
    cont_d    = cont_q;
    mem_wr    = 1'b0;
    mem_force = 1'b0;
    mem_idx   = p0;
    mem_data  = p1;
    mem_lock  = 1'b0;
    rep_load  = 1'b0;
    rep_b0    = REPLY_HDR;
    rep_b1    = 8'h00;
    if (go) begin
      leg_d = 1'b0;
      if (cm[7:3] == 5'b00100) begin
        g0_d[cm[1:0]] = cm[2];
        upd_d         = 1'b1;
      end else if (cm[7:3] == 5'b00101) begin
        g1_d[cm[1:0]] = cm[2];
        upd_d         = 1'b1;
      end
      case (cm)
        C_RESET: begin leg_d = 1'b1; cont_d = 1'b0; end
        C_STBY:  stby_d = 1'b1;
        C_PWRON: stby_d = 1'b0;
        C_CSET:  cont_d = 1'b1;
        C_CCLR:  cont_d = 1'b0;
        C_CADR, C_ADR: begin
          if (rq && (cont_q == (cm == C_CADR))) begin
            rep_load = 1'b1;
            rep_b1   = slave_addr;
          end
        end
        C_MOVC, C_MOV: begin
          if (cont_q == (cm == C_MOVC)) begin
            mem_wr    = 1'b1;
            mem_force = 1'b1;
            mem_idx   = 8'h00;
            mem_data  = p0;
          end
        end
        C_PRD: begin
          rep_load = rq;
          rep_b1   = rd_data;
        end
        C_PWR: begin
          mem_wr   = 1'b1;
          mem_lock = (fb == LOCK_FRM) && (p0 == 8'hFF) && (p1 == 8'hFF);
        end
        C_RDG0: begin rep_load = rq; rep_b1 = {{PAD_W{1'b0}}, g0_q}; end
        C_RDG1: begin rep_load = rq; rep_b1 = {{PAD_W{1'b0}}, g1_q}; end
        C_WRG0: begin g0_d = p0[GRP_W-1:0]; upd_d = 1'b1; end
        C_WRG1: begin g1_d = p0[GRP_W-1:0]; upd_d = 1'b1; end
        C_LOCUR, C_LOLO, C_LOHI: begin
          rep_load = rq;
          rep_b1   = {4'h0, lo_sel};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g0_q   <= '0;
      g1_q   <= '0;
      upd_q  <= 1'b0;
      stby_q <= 1'b0;
      leg_q  <= 1'b1;
      cont_q <= 1'b0;
    end else begin
      g0_q   <= g0_d;
      g1_q   <= g1_d;
      upd_q  <= upd_d;
      stby_q <= stby_d;
      leg_q  <= leg_d;
      cont_q <= cont_d;
    end
  end

  assign grp0   = g0_q;
  assign grp1   = g1_q;
  assign upd    = upd_q;
  assign stby   = stby_q;
  assign legacy = leg_q;
endmodule

// File: rtl/dsq_slave_core.sv
module dsq_slave_core #(
  parameter int MAX_LEN = 5,
  parameter int N_PARAM = 4,
  parameter int GRP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sof,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_eof,
  input  logic             rep_pop,
  output logic             rep_valid,
  output logic [7:0]       rep_byte,
  output logic [GRP_W-1:0] port_grp0,
  output logic [GRP_W-1:0] port_grp1,
  output logic             port_upd,
  output logic             standby,
  output logic             legacy_mode
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  logic [MAX_LEN-1:0][7:0] frm_bytes;
  logic [LEN_W-1:0]        frm_len;
  logic                    frm_ovf, frm_done;
  logic [7:0]              slave_addr, lo_tbl, rd_data, rd_idx;
  logic                    mem_wr, mem_force, mem_lock, mem_locked;
  logic [7:0]              mem_idx, mem_data;
  logic                    rep_load;
  logic [7:0]              rep_b0, rep_b1;

  dsq_frame_rx #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_eof(rx_eof), .frm_bytes(frm_bytes),
    .frm_len(frm_len), .frm_ovf(frm_ovf), .frm_done(frm_done)
  );

  dsq_param_mem #(.N_PARAM(N_PARAM)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(mem_wr), .wr_force(mem_force),
    .wr_idx(mem_idx), .wr_data(mem_data), .lock_req(mem_lock),
    .rd_idx(rd_idx), .rd_data(rd_data), .slave_addr(slave_addr),
    .lo_tbl(lo_tbl), .locked(mem_locked)
  );

  dsq_cmd_exec #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .GRP_W(GRP_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .frm_bytes(frm_bytes), .frm_len(frm_len),
    .frm_ovf(frm_ovf), .frm_done(frm_done), .slave_addr(slave_addr),
    .lo_tbl(lo_tbl), .rd_data(rd_data), .rd_idx(rd_idx), .mem_wr(mem_wr),
    .mem_force(mem_force), .mem_idx(mem_idx), .mem_data(mem_data),
    .mem_lock(mem_lock), .rep_load(rep_load), .rep_b0(rep_b0),
    .rep_b1(rep_b1), .grp0(port_grp0), .grp1(port_grp1), .upd(port_upd),
    .stby(standby), .legacy(legacy_mode)
  );

  dsq_reply_q u_rq (
    .clk(clk), .rst_n(rst_n), .load(rep_load), .ld_b0(rep_b0),
    .ld_b1(rep_b1), .pop(rep_pop), .valid(rep_valid), .head(rep_byte)
  );
endmodule

// File: rtl/dsq_slave_chk.sv
module dsq_slave_chk #(
  parameter int GRP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_done,
  input logic             rep_load,
  input logic             rep_valid,
  input logic [7:0]       rep_byte,
  input logic             lock_q,
  input logic [GRP_W-1:0] port_grp0,
  input logic [GRP_W-1:0] port_grp1,
  input logic             port_upd,
  input logic             legacy_mode
);
  assert_reply_head_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rep_load |=> (rep_valid && rep_byte == 8'hE4));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_port_change_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(port_grp0) || !$stable(port_grp1)) |-> port_upd);

  assert_upd_origin_R14: assert property (@(posedge clk) disable iff (!rst_n)
    port_upd |-> $past(frm_done));

  assert_legacy_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(legacy_mode) |-> $past(frm_done));
endmodule

bind dsq_slave_core dsq_slave_chk #(.GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .rep_load(rep_load),
  .rep_valid(rep_valid), .rep_byte(rep_byte), .lock_q(mem_locked),
  .port_grp0(port_grp0), .port_grp1(port_grp1), .port_upd(port_upd),
  .legacy_mode(legacy_mode)
);

// File: tb/sim_dsq_slave_core.sv
`timescale 1ns/1ps
module sim_dsq_slave_core;
  logic       clk, rst_n, rx_sof, rx_valid, rx_eof, rep_pop;
  logic [7:0] rx_byte, rep_byte;
  logic       rep_valid, port_upd, standby, legacy_mode;
  logic [3:0] port_grp0, port_grp1;
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  dsq_slave_core u0 (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_eof(rx_eof), .rep_pop(rep_pop),
    .rep_valid(rep_valid), .rep_byte(rep_byte), .port_grp0(port_grp0),
    .port_grp1(port_grp1), .port_upd(port_upd), .standby(standby),
    .legacy_mode(legacy_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // returns at the falling edge right after the results are registered
  task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] b3 = 8'h00,
                      input logic [7:0] b4 = 8'h00, input logic [7:0] b5 = 8'h00);
    logic [7:0] bb [6];
    bb = '{b0, b1, b2, b3, b4, b5};
    @(negedge clk) rx_sof = 1'b1;
    @(negedge clk) rx_sof = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_byte  = bb[i];
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_eof   = 1'b1;
    @(negedge clk) rx_eof = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop1;
    rep_pop = 1'b1;
    @(negedge clk) rep_pop = 1'b0;
  endtask

  task automatic get_reply(input string tag, input logic [7:0] data);
    chk({tag, " reply pending"}, rep_valid, 1);
    chk({tag, " reply header"}, rep_byte, 8'hE4);
    pop1();
    chk({tag, " reply data"}, rep_byte, data);
    chk({tag, " second byte valid"}, rep_valid, 1);
    pop1();
    chk({tag, " queue drained"}, rep_valid, 0);
  endtask

  task automatic no_reply(input string tag);
    chk({tag, " no reply"}, rep_valid, 0);
  endtask

  task automatic t_reset;
    chk("R9 legacy after reset", legacy_mode, 1);
    chk("R3 grp0 after reset", port_grp0, 0);
    chk("R3 grp1 after reset", port_grp1, 0);
    chk("R10 standby after reset", standby, 0);
    chk("R13 queue empty after reset", rep_valid, 0);
  endtask

  task automatic t_addr;
    send(3, 8'hE0, 8'h15, 8'h24);
    chk("R1 foreign address ignored", port_grp0, 4'h0);
    chk("R9 legacy kept on foreign frame", legacy_mode, 1);
    send(3, 8'hE0, 8'h14, 8'h24);
    chk("R1 own address band high", port_grp0, 4'h1);
    chk("R9 legacy dropped", legacy_mode, 0);
    send(3, 8'hE0, 8'h10, 8'h25);
    chk("R1 address 10h", port_grp0, 4'h3);
    send(3, 8'hE0, 8'h00, 8'h26);
    chk("R1 address 00h", port_grp0, 4'h7);
  endtask

  task automatic t_framing;
    send(3, 8'hE4, 8'h14, 8'h27);
    chk("R2 framing E4h ignored", port_grp0, 4'h7);
    send(3, 8'hE0, 8'h14, 8'h14);
    no_reply("R2 E0h read");
    send(3, 8'hE3, 8'h14, 8'h14);
    get_reply("R2 E3h read grp0", 8'h07);
  endtask

  task automatic t_switch;
    send(3, 8'hE0, 8'h14, 8'h2D);
    chk("R14 upd pulse", port_upd, 1);
    chk("R3 S2 input B", port_grp1, 4'h2);
    @(negedge clk);
    chk("R14 upd one cycle", port_upd, 0);
    send(3, 8'hE0, 8'h14, 8'h2C);
    chk("R3 S1 input B", port_grp1, 4'h3);
    send(3, 8'hE0, 8'h14, 8'h29);
    chk("R3 S2 input A", port_grp1, 4'h1);
    send(3, 8'hE0, 8'h14, 8'h20);
    chk("R3 band low", port_grp0, 4'h6);
    send(3, 8'hE0, 8'h14, 8'h2B);
    chk("R14 upd without change", port_upd, 1);
    chk("R3 S4 input A unchanged", port_grp1, 4'h1);
  endtask

  task automatic t_group;
    send(4, 8'hE0, 8'h14, 8'h38, 8'hA5);
    chk("R4 write grp0", port_grp0, 4'h5);
    send(4, 8'hE0, 8'h14, 8'h39, 8'h3C);
    chk("R4 write grp1", port_grp1, 4'hC);
    send(3, 8'hE2, 8'h14, 8'h15);
    get_reply("R4 read grp1", 8'h0C);
  endtask

  task automatic t_length;
    send(3, 8'hE0, 8'h14, 8'h38);
    chk("R12 short group write", port_grp0, 4'h5);
    send(4, 8'hE0, 8'h14, 8'h22, 8'h55);
    chk("R12 long switch cmd", port_grp0, 4'h5);
    send(6, 8'hE0, 8'h14, 8'h22, 8'h00, 8'h00, 8'h00);
    chk("R12 overlong frame", port_grp0, 4'h5);
    send(3, 8'hE2, 8'h14, 8'h77);
    no_reply("R12 unknown cmd");
    chk("R12 unknown cmd ports", port_grp1, 4'hC);
  endtask

  task automatic t_contention;
    send(3, 8'hE2, 8'h14, 8'h05);
    no_reply("R5 05h flag clear");
    send(3, 8'hE2, 8'h14, 8'h07);
    get_reply("R5 07h flag clear", 8'h14);
    send(3, 8'hE0, 8'h14, 8'h04);
    send(3, 8'hE2, 8'h14, 8'h07);
    no_reply("R5 07h flag set");
    send(3, 8'hE2, 8'h14, 8'h05);
    get_reply("R5 05h flag set", 8'h14);
  endtask

  task automatic t_move;
    send(4, 8'hE0, 8'h14, 8'h09, 8'h33);
    send(3, 8'hE2, 8'h33, 8'h05);
    no_reply("R6 09h refused while flag set");
    send(4, 8'hE0, 8'h14, 8'h08, 8'h33);
    send(3, 8'hE2, 8'h33, 8'h05);
    get_reply("R6 08h moved address", 8'h33);
    send(3, 8'hE2, 8'h14, 8'h05);
    no_reply("R6 old address dropped");
    send(3, 8'hE0, 8'h33, 8'h06);
    send(4, 8'hE0, 8'h33, 8'h09, 8'h14);
    send(3, 8'hE2, 8'h14, 8'h07);
    get_reply("R6 09h moved back", 8'h14);
  endtask

  task automatic t_params;
    send(4, 8'hE2, 8'h14, 8'h0D, 8'h02);
    get_reply("R7 default config", 8'h0A);
    send(5, 8'hE0, 8'h14, 8'h0F, 8'h03, 8'h5A);
    send(4, 8'hE2, 8'h14, 8'h0D, 8'h03);
    get_reply("R7 read written", 8'h5A);
    send(4, 8'hE2, 8'h14, 8'h0D, 8'h09);
    get_reply("R7 out of range", 8'hFF);
  endtask

  task automatic t_lo;
    send(5, 8'hE0, 8'h14, 8'h0F, 8'h01, 8'h73);
    send(3, 8'hE2, 8'h14, 8'h51);
    get_reply("R11 current high", 8'h07);
    send(3, 8'hE2, 8'h14, 8'h52);
    get_reply("R11 low entry", 8'h03);
    send(3, 8'hE2, 8'h14, 8'h53);
    get_reply("R11 high entry", 8'h07);
    send(3, 8'hE0, 8'h14, 8'h20);
    send(3, 8'hE2, 8'h14, 8'h51);
    get_reply("R11 current low", 8'h03);
  endtask

  task automatic t_lock;
    send(5, 8'hE1, 8'h14, 8'h0F, 8'hFF, 8'hFF);
    send(5, 8'hE0, 8'h14, 8'h0F, 8'h03, 8'h66);
    send(4, 8'hE2, 8'h14, 8'h0D, 8'h03);
    get_reply("R8 E1h does not lock", 8'h66);
    send(5, 8'hE0, 8'h14, 8'h0F, 8'hFF, 8'hFF);
    send(5, 8'hE0, 8'h14, 8'h0F, 8'h03, 8'h11);
    send(4, 8'hE2, 8'h14, 8'h0D, 8'h03);
    get_reply("R8 write after lock", 8'h66);
  endtask

  task automatic t_standby;
    send(3, 8'hE0, 8'h14, 8'h02);
    chk("R10 standby on", standby, 1);
    send(3, 8'hE0, 8'h14, 8'h03);
    chk("R10 standby off", standby, 0);
  endtask

  task automatic t_queue;
    send(3, 8'hE2, 8'h14, 8'h14);
    send(3, 8'hE2, 8'h14, 8'h52);
    get_reply("R13 overwrite full queue", 8'h03);
    send(3, 8'hE2, 8'h14, 8'h14);
    pop1();
    chk("R13 second byte grp0", rep_byte, 8'h04);
    send(3, 8'hE2, 8'h14, 8'h53);
    get_reply("R13 overwrite half queue", 8'h07);
  endtask

  task automatic t_legacy;
    send(3, 8'hE0, 8'h14, 8'h04);
    chk("R9 legacy still off", legacy_mode, 0);
    send(3, 8'hE0, 8'h14, 8'h00);
    chk("R9 reset cmd restores legacy", legacy_mode, 1);
    send(3, 8'hE2, 8'h14, 8'h07);
    get_reply("R9 reset cmd clears contention", 8'h14);
    chk("R9 legacy dropped again", legacy_mode, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_sof = 1'b0; rx_valid = 1'b0; rx_eof = 1'b0;
    rx_byte = 8'h00; rep_pop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_framing();
    t_switch();
    t_group();
    t_length();
    t_contention();
    t_move();
    t_params();
    t_lo();
    t_lock();
    t_standby();
    t_queue();
    t_legacy();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule